// File: doc/BRIEF.md
# Rank Refresh Scheduler with Tiered Urgency

This block tracks refresh debt for one DRAM rank and asks the command arbiter for REFRESH commands at one of three urgency levels. A free-running interval timer adds one owed refresh each time the programmed average refresh interval elapses. An accepted grant pays one back. The request is opportunistic when the rank has been idle long enough. It rises to high priority when the debt reaches a programmable high watermark. It rises to panic when the debt reaches a higher panic watermark, or when the time since the last refresh exceeds a coarse maximum-gap limit.

After a refresh is accepted, the block enters a blocked state for the programmed refresh-cycle time. During that time the arbiter must not issue an ACT or another refresh to the rank, and no new request is raised. One instance sits beside each rank. The arbiter that chooses among ranks and the command encoder live elsewhere.

The control is a two-state machine. READY means the rank may be refreshed and a request may be shown. BLOCK means a refresh is in progress. READY goes to BLOCK on an accepted grant when the refresh-cycle time is nonzero. BLOCK goes back to READY when its countdown reaches zero.

Top module: `rank_refresh_sched`

## Requirements
- R1: While reset is held, and in the first cycle after it, `ref_req` is 0 (none), `rank_blocked` is 0 and the owed count is 0.
- R2: The owed count rises by one every `cfg_intv` clock cycles, counted from reset release. A `cfg_intv` of 0 stops accumulation.
- R3: The owed count saturates at 15. It falls by one on each accepted grant and never goes below 0.
- R4: `ref_req` is 1 (opportunistic) when the owed count is nonzero and `rank_idle` has been high for at least `cfg_idle_thr` consecutive cycles, and nothing more urgent applies.
- R5: `ref_req` is 2 (high) when the owed count is nonzero and at least `cfg_hi_wm`, and panic does not apply.
- R6: `ref_req` is 3 (panic) when the owed count is nonzero and at least `cfg_panic_wm`. Panic takes precedence over high, and high takes precedence over opportunistic.
- R7: The block counts elapsed units of GAP_UNIT cycles since reset or the last accepted grant. When that count reaches a nonzero `cfg_max_gap`, the request becomes panic regardless of the owed count. A limit of 0 disables this check.
- R8: A grant is accepted only when `ref_req` is nonzero and the rank is not blocked. Any other grant changes nothing.
- R9: After an accepted grant, `rank_blocked` is high for exactly `cfg_trfc` cycles, starting the next cycle, and `ref_req` is 0 throughout. A `cfg_trfc` of 0 causes no block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (DCLK) |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_intv | input | 16 | Average refresh interval in cycles |
| cfg_trfc | input | 9 | Refresh-cycle time in cycles |
| cfg_idle_thr | input | 8 | Idle cycles that make an opportunity |
| cfg_hi_wm | input | 4 | High-priority watermark on owed count |
| cfg_panic_wm | input | 4 | Panic watermark on owed count |
| cfg_max_gap | input | 8 | Maximum gap in GAP_UNIT-cycle units, 0 disables |
| rank_idle | input | 1 | Rank has no pending traffic this cycle |
| ref_grant | input | 1 | Arbiter issues the refresh this cycle |
| ref_req | output | 2 | Request level: 0 none, 1 opportunistic, 2 high, 3 panic |
| rank_blocked | output | 1 | No ACT or refresh may be sent to the rank |

## Verification
The bench builds the block with GAP_UNIT set to 4 in place of the default 1024, so a maximum-gap limit of 3 expires after 12 cycles and panic from a late refresh can be observed directly. All other widths keep their defaults. Intervals of 5 to 10 cycles let the owed count reach both watermarks and its ceiling of 15 within a few hundred cycles. The directed part drives grants while blocked and while no request is shown, and uses a zero refresh-cycle time, so ignored grants and the missing block are both visible at the ports.

// File: rtl/refsch_pkg.sv
package refsch_pkg;

    typedef enum logic [1:0] {
        REQ_NONE  = 2'd0,
        REQ_OPP   = 2'd1,
        REQ_HIGH  = 2'd2,
        REQ_PANIC = 2'd3
    } req_lvl_t;

    typedef enum logic {
        ST_READY = 1'b0,
        ST_BLOCK = 1'b1
    } blk_state_t;

endpackage

// File: rtl/refsch_interval.sv
// Free-running interval timer: one tick every 'period' cycles, none when period is 0.
module refsch_interval #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] period,
    output logic         tick
);
    logic [W-1:0] cnt;
    logic [W:0]   cnt_inc;

    assign cnt_inc = {1'b0, cnt} + {{W{1'b0}}, 1'b1};
    assign tick    = (period != '0) && (cnt_inc == {1'b0, period});

    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt_inc[W-1:0];
    end
endmodule

// File: rtl/refsch_debt.sv
// Saturating owed-refresh counter.
module refsch_debt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         dec,
    output logic [W-1:0] owed
);
    localparam logic [W-1:0] OWED_MAX = '1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owed <= '0;
        end else begin
            unique case ({inc, dec})
                2'b10:   if (owed != OWED_MAX) owed <= owed + 1'b1;
                2'b01:   if (owed != '0)       owed <= owed - 1'b1;
                default: owed <= owed;
            endcase
        end
    end
endmodule

// File: rtl/refsch_idle.sv
// Consecutive idle-cycle counter with threshold compare.
module refsch_idle #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         idle,
    input  logic [W-1:0] thr,
    output logic         reached
);
    localparam logic [W-1:0] RUN_MAX = '1;
    logic [W-1:0] run;

    always_ff @(posedge clk) begin
        if (!rst_n)              run <= '0;
        else if (!idle)          run <= '0;
        else if (run != RUN_MAX) run <= run + 1'b1;
    end

    assign reached = (run >= thr);
endmodule

// File: rtl/refsch_gap.sv
// Coarse timer of GAP_UNIT-cycle units since the last refresh; flags overdue.
module refsch_gap #(
    parameter int W        = 8,
    parameter int GAP_UNIT = 1024
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic [W-1:0] limit,
    output logic         overdue
);
    localparam logic [W-1:0] UNITS_MAX = '1;
    logic         unit_tick;
    logic [W-1:0] units;

    generate
        if (GAP_UNIT <= 1) begin : g_no_pre
            assign unit_tick = 1'b1;
        end else begin : g_pre
            localparam int PRE_W = $clog2(GAP_UNIT);
            localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(GAP_UNIT - 1);
            logic [PRE_W-1:0] pcnt;

            assign unit_tick = (pcnt == PRE_LAST);

            always_ff @(posedge clk) begin
                if (!rst_n || clear) pcnt <= '0;
                else if (unit_tick)  pcnt <= '0;
                else                 pcnt <= pcnt + 1'b1;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n || clear)                       units <= '0;
        else if (unit_tick && units != UNITS_MAX)  units <= units + 1'b1;
    end

    assign overdue = (limit != '0) && (units >= limit);
endmodule

// File: rtl/rank_refresh_sched.sv
module rank_refresh_sched
    import refsch_pkg::*;
#(
    parameter int INTV_W   = 16,
    parameter int TRFC_W   = 9,
    parameter int IDLE_W   = 8,
    parameter int WM_W     = 4,
    parameter int GAP_W    = 8,
    parameter int GAP_UNIT = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [INTV_W-1:0] cfg_intv,
    input  logic [TRFC_W-1:0] cfg_trfc,
    input  logic [IDLE_W-1:0] cfg_idle_thr,
    input  logic [WM_W-1:0]   cfg_hi_wm,
    input  logic [WM_W-1:0]   cfg_panic_wm,
    input  logic [GAP_W-1:0]  cfg_max_gap,
    input  logic              rank_idle,
    input  logic              ref_grant,
    output logic [1:0]        ref_req,
    output logic              rank_blocked
);
    blk_state_t        state, state_nxt;
    logic [TRFC_W-1:0] blk_tmr;
    logic              intv_tick;
    logic              idle_ok;
    logic              gap_over;
    logic [WM_W-1:0]   owed_cnt;
    logic              accept;
    logic              hi_hit, panic_hit;
    req_lvl_t          req_lvl;

    refsch_interval #(.W(INTV_W)) u_intv (
        .clk    (clk),
        .rst_n  (rst_n),
        .period (cfg_intv),
        .tick   (intv_tick)
    );

    refsch_debt #(.W(WM_W)) u_debt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (intv_tick),
        .dec   (accept),
        .owed  (owed_cnt)
    );

    refsch_idle #(.W(IDLE_W)) u_idle (
        .clk     (clk),
        .rst_n   (rst_n),
        .idle    (rank_idle),
        .thr     (cfg_idle_thr),
        .reached (idle_ok)
    );

    refsch_gap #(.W(GAP_W), .GAP_UNIT(GAP_UNIT)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .limit   (cfg_max_gap),
        .overdue (gap_over)
    );

    // A grant counts only while a request is shown outside the blocked window.
    assign accept    = ref_grant && (state == ST_READY) && (req_lvl != REQ_NONE);
    assign hi_hit    = (owed_cnt != '0) && (owed_cnt >= cfg_hi_wm);
    assign panic_hit = (owed_cnt != '0) && (owed_cnt >= cfg_panic_wm);

    // Next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_READY: if (accept && cfg_trfc != '0) state_nxt = ST_BLOCK;
            ST_BLOCK: if (blk_tmr == '0)            state_nxt = ST_READY;
            default:  state_nxt = ST_READY;
        endcase
    end

    // State register and refresh-cycle countdown
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_READY;
            blk_tmr <= '0;
        end else begin
            state <= state_nxt;
            if (accept && cfg_trfc != '0)
                blk_tmr <= cfg_trfc - 1'b1;
            else if (state == ST_BLOCK && blk_tmr != '0)
                blk_tmr <= blk_tmr - 1'b1;
        end
    end

    // Outputs
    always_comb begin
        req_lvl      = REQ_NONE;
        rank_blocked = 1'b0;
        unique case (state)
            ST_READY: begin
                if (panic_hit || gap_over)          req_lvl = REQ_PANIC;
                else if (hi_hit)                    req_lvl = REQ_HIGH;
                else if (owed_cnt != '0 && idle_ok) req_lvl = REQ_OPP;
                else                                req_lvl = REQ_NONE;
            end
            ST_BLOCK: begin
                rank_blocked = 1'b1;
                req_lvl      = REQ_NONE;
            end
            default: begin
                req_lvl      = REQ_NONE;
                rank_blocked = 1'b0;
            end
        endcase
    end

    assign ref_req = req_lvl;
endmodule

// File: rtl/refsch_checker.sv
module refsch_checker #(
    parameter int TRFC_W = 9,
    parameter int WM_W   = 4,
    parameter int GAP_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [TRFC_W-1:0] cfg_trfc,
    input logic [WM_W-1:0]   cfg_panic_wm,
    input logic [GAP_W-1:0]  cfg_max_gap,
    input logic              ref_grant,
    input logic [1:0]        ref_req,
    input logic              rank_blocked,
    input logic [WM_W-1:0]   owed
);
    localparam logic [WM_W:0] ONE_X = (WM_W+1)'(1);

    // R9: nothing requested while blocked
    p_quiet_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rank_blocked |-> ref_req == 2'd0);

    // R9: accepted grant with nonzero refresh-cycle time blocks the next cycle
    p_grant_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_grant && ref_req != 2'd0 && !rank_blocked && cfg_trfc != '0) |=> rank_blocked);

    // R3: the owed count moves by at most one per cycle
    p_debt_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((owed == $past(owed)) ||
                  ({1'b0, owed} == {1'b0, $past(owed)} + ONE_X) ||
                  ({1'b0, owed} + ONE_X == {1'b0, $past(owed)})));

    // R8: an ignored grant never pays back debt
    p_ignored_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_grant && (ref_req == 2'd0 || rank_blocked)) |=> owed >= $past(owed));

    // R4: an opportunistic request needs debt
    p_opp_needs_debt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req == 2'd1) |-> owed != '0);

    // R6: debt at the panic watermark shows panic when not blocked
    p_panic_wm_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!rank_blocked && owed != '0 && owed >= cfg_panic_wm) |-> ref_req == 2'd3);

    // R7: with the gap check off and no debt, nothing is requested
    p_no_debt_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (owed == '0 && cfg_max_gap == '0) |-> ref_req == 2'd0);
endmodule

bind rank_refresh_sched refsch_checker #(
    .TRFC_W (TRFC_W),
    .WM_W   (WM_W),
    .GAP_W  (GAP_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_trfc     (cfg_trfc),
    .cfg_panic_wm (cfg_panic_wm),
    .cfg_max_gap  (cfg_max_gap),
    .ref_grant    (ref_grant),
    .ref_req      (ref_req),
    .rank_blocked (rank_blocked),
    .owed         (owed_cnt)
);

// File: tb/sim_rank_refresh_sched.sv
`timescale 1ns/1ps
module sim_rank_refresh_sched;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_intv = '0;
    logic [8:0]  cfg_trfc = '0;
    logic [7:0]  cfg_idle_thr = '0;
    logic [3:0]  cfg_hi_wm = '0;
    logic [3:0]  cfg_panic_wm = '0;
    logic [7:0]  cfg_max_gap = '0;
    logic        rank_idle = 1'b0;
    logic        ref_grant = 1'b0;
    logic [1:0]  ref_req;
    logic        rank_blocked;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rank_refresh_sched #(.GAP_UNIT(4)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_intv     (cfg_intv),
        .cfg_trfc     (cfg_trfc),
        .cfg_idle_thr (cfg_idle_thr),
        .cfg_hi_wm    (cfg_hi_wm),
        .cfg_panic_wm (cfg_panic_wm),
        .cfg_max_gap  (cfg_max_gap),
        .rank_idle    (rank_idle),
        .ref_grant    (ref_grant),
        .ref_req      (ref_req),
        .rank_blocked (rank_blocked)
    );

    typedef struct packed {
        logic [15:0] intv;
        logic [7:0]  thr;
        logic [3:0]  hi;
        logic [3:0]  pan;
        logic [7:0]  gap;
        logic        idle;
        logic [15:0] n;
        logic [1:0]  exp;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t TBL [NV] = '{
        '{16'd10,   8'd5,   4'd4,  4'd8,  8'd0, 1'b0, 16'd5,   2'd0},
        '{16'd10,   8'd5,   4'd4,  4'd8,  8'd0, 1'b0, 16'd10,  2'd0},
        '{16'd10,   8'd5,   4'd4,  4'd8,  8'd0, 1'b1, 16'd10,  2'd1},
        '{16'd10,   8'd20,  4'd4,  4'd8,  8'd0, 1'b1, 16'd10,  2'd0},
        '{16'd10,   8'd5,   4'd4,  4'd8,  8'd0, 1'b0, 16'd40,  2'd2},
        '{16'd10,   8'd5,   4'd4,  4'd8,  8'd0, 1'b1, 16'd39,  2'd1},
        '{16'd10,   8'd5,   4'd4,  4'd8,  8'd0, 1'b0, 16'd80,  2'd3},
        '{16'd5,    8'd5,   4'd15, 4'd15, 8'd0, 1'b0, 16'd200, 2'd3},
        '{16'd0,    8'd0,   4'd1,  4'd8,  8'd0, 1'b1, 16'd50,  2'd0},
        '{16'd1000, 8'd200, 4'd4,  4'd8,  8'd3, 1'b0, 16'd12,  2'd3},
        '{16'd1000, 8'd200, 4'd4,  4'd8,  8'd3, 1'b0, 16'd11,  2'd0},
        '{16'd10,   8'd200, 4'd2,  4'd2,  8'd0, 1'b0, 16'd20,  2'd3}
    };

    function automatic string row_tag(input int i);
        case (i)
            0, 8:        return "R2";
            1, 2, 3, 5:  return "R4";
            4:           return "R5";
            6, 11:       return "R6";
            7:           return "R3";
            default:     return "R7";
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_reset(input logic [15:0] iv, input logic [7:0] th,
                            input logic [3:0] hw, input logic [3:0] pw,
                            input logic [7:0] gp, input logic [8:0] tr,
                            input logic idl);
        rst_n = 1'b0;
        ref_grant = 1'b0;
        cfg_intv = iv; cfg_idle_thr = th; cfg_hi_wm = hw;
        cfg_panic_wm = pw; cfg_max_gap = gp; cfg_trfc = tr;
        rank_idle = idl;
        run(2);
        rst_n = 1'b1;
    endtask

    initial begin
        // R1: reset state
        do_reset(16'd1, 8'd0, 4'd1, 4'd1, 8'd1, 9'd2, 1'b1);
        rst_n = 1'b0;
        run(1);
        chk("R1 req in reset", ref_req, 0);
        chk("R1 blocked in reset", rank_blocked, 0);
        rst_n = 1'b1;
        #0.5;
        chk("R1 req after reset", ref_req, 0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            do_reset(TBL[i].intv, TBL[i].thr, TBL[i].hi, TBL[i].pan,
                     TBL[i].gap, 9'd0, TBL[i].idle);
            run(int'(TBL[i].n));
            chk(row_tag(i), ref_req, int'(TBL[i].exp));
        end

        // R9: block window after an accepted grant
        do_reset(16'd10, 8'd255, 4'd1, 4'd8, 8'd0, 9'd3, 1'b0);
        run(10);
        chk("R5 before grant", ref_req, 2);
        ref_grant = 1'b1;
        run(1);
        ref_grant = 1'b0;
        chk("R9 blocked after grant", rank_blocked, 1);
        chk("R9 no request while blocked", ref_req, 0);
        run(2);
        chk("R9 blocked last cycle", rank_blocked, 1);
        run(1);
        chk("R9 released after trfc", rank_blocked, 0);
        chk("R3 debt paid back", ref_req, 0);
        // R8: grant with no request is ignored
        ref_grant = 1'b1;
        run(1);
        ref_grant = 1'b0;
        chk("R8 idle grant no block", rank_blocked, 0);
        run(5);
        chk("R3 floor then new debt", ref_req, 2);

        // R8: grants during the block do not pay back debt
        do_reset(16'd5, 8'd255, 4'd2, 4'd8, 8'd0, 9'd4, 1'b0);
        run(10);
        chk("R5 two owed", ref_req, 2);
        ref_grant = 1'b1;
        run(3);
        ref_grant = 1'b0;
        chk("R9 still blocked", rank_blocked, 1);
        run(2);
        chk("R9 released", rank_blocked, 0);
        chk("R8 blocked grants ignored", ref_req, 2);

        // R7 / R9: zero trfc, gap timer cleared by grant
        do_reset(16'd1000, 8'd255, 4'd1, 4'd8, 8'd3, 9'd0, 1'b0);
        run(12);
        chk("R7 gap panic", ref_req, 3);
        ref_grant = 1'b1;
        run(1);
        ref_grant = 1'b0;
        chk("R9 zero trfc no block", rank_blocked, 0);
        chk("R7 gap cleared", ref_req, 0);
        run(11);
        chk("R7 gap below limit", ref_req, 0);
        run(1);
        chk("R7 gap reached again", ref_req, 3);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(5ns * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule